// File: doc/BRIEF.md
# Hash Engine Register Front End

This block is a slave register bank on a single-cycle strobe bus. It stands between software and a hash compression engine. Software writes a 512-bit message block as sixteen 32-bit words and then issues a command through a control register. The command either starts a fresh hash from the initial value or chains from the previous result. Software polls a status register and reads the 256-bit digest back as eight words. Three identity registers return a fixed ASCII name and version.

Each bus access lasts one strobe cycle. Acknowledge, error and read data are combinational, so they are valid in the same cycle as the strobe. A command write moves a small sequencer through three named states: `CMD_IDLE`, `CMD_INIT` and `CMD_NEXT`. Every state leaves on the next clock. A control write with bit 0 set goes to `CMD_INIT`. A control write with bit 1 set and bit 0 clear goes to `CMD_NEXT`. Any other cycle returns to `CMD_IDLE`. The engine sees `eng_init` high only in `CMD_INIT` and `eng_next` high only in `CMD_NEXT`. Each command write therefore gives exactly one engine cycle, whatever the control bits hold afterwards.

Top module: `hash_bus_regs`

## Requirements
- R1: Reads of 0x00 and 0x01 return the eight-character ASCII name "hashbank", first character in bits 31:24 of 0x00. A read of 0x02 returns the ASCII version "0.90", first character in bits 31:24.
- R2: The control register sits at 0x08, with bit 0 = init and bit 1 = next. A read returns the two bits last written, and bits 31:2 read as zero.
- R3: A control write with bit 0 set drives `eng_init` high for exactly the following cycle. With bit 1 set and bit 0 clear, `eng_next` is driven instead. With both bits set, only `eng_init` is driven. Neither is ever high unless the previous cycle held a control write, even while the stored bits stay set.
- R4: Block word i is written and read at 0x10+i (i = 0..15). It appears on `eng_block[511-32i -: 32]`, so 0x10 holds the most significant word. A read returns the last value written.
- R5: A read of 0x09 returns `eng_ready` in bit 0 and `eng_digest_valid` in bit 1, live in the same cycle. Bits 31:2 read as zero.
- R6: A read of 0x20+i (i = 0..7) returns `eng_digest[255-32i -: 32]` live, so the digest stays readable after every block.
- R7: With the strobe high, `bus_ack` is high in the same cycle for any read of a mapped address and for a write to 0x08 or 0x10..0x1F. `bus_err` is high instead for an unmapped address or a write to a read-only register. Both are low when the strobe is low.
- R8: A read of an unmapped address returns zero. An erroring write changes no register and starts no command.
- R9: Reset clears the block words, the control register and both command outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_ack | output | 1 | Access accepted |
| bus_err | output | 1 | Access refused |
| eng_init | output | 1 | One-cycle command: hash from the initial value |
| eng_next | output | 1 | One-cycle command: chain from the previous value |
| eng_block | output | 512 | Message block, word 0x10 in the top bits |
| eng_ready | input | 1 | Engine idle |
| eng_digest | input | 256 | Engine result |
| eng_digest_valid | input | 1 | Engine result is valid |

## Verification
The hardest case to reach from the ports is a command write that lands while the sequencer is already in a firing state. Another is a control word carrying both command bits at once. The stimulus reaches both by issuing control writes in consecutive strobe cycles (init followed at once by a clearing write, then init and next together) and holding the bits set over idle cycles. A reference model compares both command outputs and the block bus on every clock. A behavioural engine in the bench answers each command after a delay with a result that depends on the block and the previous value. This exposes the chaining between an init block and a following next block through the digest reads.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ID,
        RGN_CTRL,
        RGN_STAT,
        RGN_BLOCK,
        RGN_DIGEST
    } region_e;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_INIT,
        CMD_NEXT
    } cmd_state_e;

    // Address map; the block and digest word order is fixed by the engine.
    localparam int A_ID_LO  = 8'h00;
    localparam int A_ID_HI  = 8'h02;
    localparam int A_CTRL   = 8'h08;
    localparam int A_STAT   = 8'h09;
    localparam int A_BLOCK  = 8'h10;
    localparam int A_DIGEST = 8'h20;

    localparam int CTL_INIT_BIT = 0;
    localparam int CTL_NEXT_BIT = 1;
    localparam int CTL_W        = 2;

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BLK_WORDS  = 16,
    parameter int DIG_WORDS  = 8,
    parameter int IDX_W      = 4
) (
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output logic              ack,
    output logic              err
);

    logic writable;
    int   a;

    always_comb begin
        a      = int'(addr);
        region = RGN_NONE;
        idx    = '0;
        if (a >= A_ID_LO && a <= A_ID_HI) begin
            region = RGN_ID;
            idx    = IDX_W'(a - A_ID_LO);
        end else if (a == A_CTRL) begin
            region = RGN_CTRL;
        end else if (a == A_STAT) begin
            region = RGN_STAT;
        end else if (a >= A_BLOCK && a < A_BLOCK + BLK_WORDS) begin
            region = RGN_BLOCK;
            idx    = IDX_W'(a - A_BLOCK);
        end else if (a >= A_DIGEST && a < A_DIGEST + DIG_WORDS) begin
            region = RGN_DIGEST;
            idx    = IDX_W'(a - A_DIGEST);
        end
    end

    assign writable = (region == RGN_CTRL) || (region == RGN_BLOCK);
    assign ack      = stb && (region != RGN_NONE) && (!we || writable);
    assign err      = stb && ((region == RGN_NONE) || (we && !writable));

endmodule

// File: rtl/hbr_words.sv
module hbr_words #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    output logic [WORDS*DATA_W-1:0] flat
);

    localparam int FLAT_W = WORDS * DATA_W;

    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (wr_en && (int'(wr_idx) == i)) begin
                word_q[i] <= wr_data;
            end
        end
        // Word 0 occupies the most significant slot of the engine bus.
        assign flat[FLAT_W-1-i*DATA_W -: DATA_W] = word_q[i];
    end

    assign rd_data = (int'(rd_idx) < WORDS) ? word_q[rd_idx] : '0;

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat));  // R4

endmodule

// File: rtl/hbr_cmd_fsm.sv
module hbr_cmd_fsm
    import hbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctrl_q,
    output logic             fire_init,
    output logic             fire_next
);

    cmd_state_e state_q;
    cmd_state_e state_nx;
    cmd_state_e req;

    // Requested command from this cycle's write; init outranks next.
    always_comb begin
        req = CMD_IDLE;
        if (wr_en) begin
            if (wr_data[CTL_INIT_BIT]) begin
                req = CMD_INIT;
            end else if (wr_data[CTL_NEXT_BIT]) begin
                req = CMD_NEXT;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            CMD_IDLE: state_nx = req;
            CMD_INIT: state_nx = req;
            CMD_NEXT: state_nx = req;
            default:  state_nx = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        fire_init = 1'b0;
        fire_next = 1'b0;
        unique case (state_q)
            CMD_IDLE: ;
            CMD_INIT: fire_init = 1'b1;
            CMD_NEXT: fire_next = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    AST_INIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        fire_init |-> $past(wr_en && wr_data[CTL_INIT_BIT]));  // R3
    AST_NEXT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        fire_next |-> $past(wr_en && wr_data[CTL_NEXT_BIT] && !wr_data[CTL_INIT_BIT]));  // R3
    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fire_init && fire_next));  // R3
    AST_NO_SPONTANEOUS_CMD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!fire_init && !fire_next));  // R3

endmodule

// File: rtl/hash_bus_regs.sv
module hash_bus_regs
    import hbr_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          BLK_WORDS = 16,
    parameter int          DIG_WORDS = 8,
    parameter logic [63:0] CORE_NAME = "hashbank",
    parameter logic [31:0] CORE_VER  = "0.90"
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_stb,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_ack,
    output logic                        bus_err,
    output logic                        eng_init,
    output logic                        eng_next,
    output logic [BLK_WORDS*DATA_W-1:0] eng_block,
    input  logic                        eng_ready,
    input  logic [DIG_WORDS*DATA_W-1:0] eng_digest,
    input  logic                        eng_digest_valid
);

    localparam int MAX_WORDS = (BLK_WORDS > DIG_WORDS) ? BLK_WORDS : DIG_WORDS;
    localparam int IDX_W     = (MAX_WORDS > 4) ? $clog2(MAX_WORDS) : 2;
    localparam int DIG_BITS  = DIG_WORDS * DATA_W;

    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic              acc_ok;
    logic              blk_wr;
    logic              ctl_wr;
    logic [DATA_W-1:0] blk_rd;
    logic [CTL_W-1:0]  ctrl_q;
    logic [DATA_W-1:0] rd_mux;

    hbr_decode #(
        .ADDR_W    (ADDR_W),
        .BLK_WORDS (BLK_WORDS),
        .DIG_WORDS (DIG_WORDS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .stb    (bus_stb),
        .we     (bus_we),
        .addr   (bus_addr),
        .region (region),
        .idx    (idx),
        .ack    (acc_ok),
        .err    (bus_err)
    );

    assign bus_ack = acc_ok;
    assign blk_wr  = acc_ok && bus_we && (region == RGN_BLOCK);
    assign ctl_wr  = acc_ok && bus_we && (region == RGN_CTRL);

    hbr_words #(
        .DATA_W (DATA_W),
        .WORDS  (BLK_WORDS),
        .IDX_W  (IDX_W)
    ) u_words (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (blk_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .rd_idx  (idx),
        .rd_data (blk_rd),
        .flat    (eng_block)
    );

    hbr_cmd_fsm u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctl_wr),
        .wr_data   (bus_wdata[CTL_W-1:0]),
        .ctrl_q    (ctrl_q),
        .fire_init (eng_init),
        .fire_next (eng_next)
    );

    always_comb begin
        rd_mux = '0;
        unique case (region)
            RGN_ID: begin
                if (idx == IDX_W'(0)) begin
                    rd_mux = CORE_NAME[63:32];
                end else if (idx == IDX_W'(1)) begin
                    rd_mux = CORE_NAME[31:0];
                end else begin
                    rd_mux = CORE_VER;
                end
            end
            RGN_CTRL:   rd_mux = DATA_W'(ctrl_q);
            RGN_STAT:   rd_mux = DATA_W'({eng_digest_valid, eng_ready});
            RGN_BLOCK:  rd_mux = blk_rd;
            RGN_DIGEST: rd_mux = eng_digest[DIG_BITS-1-int'(idx)*DATA_W -: DATA_W];
            RGN_NONE:   rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    assign bus_rdata = (bus_stb && !bus_we) ? rd_mux : '0;

    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_stb |-> (!bus_ack && !bus_err));  // R7
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_we && bus_err) |-> (bus_rdata == '0));  // R8
    AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (eng_block == '0 && !eng_init && !eng_next));  // R9
    AST_ERR_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_err) |=> (!eng_init && !eng_next));  // R8

endmodule

// File: tb/hash_bus_regs_test.sv
module hash_bus_regs_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stb = 1'b0;
    logic         bwe = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         ack;
    logic         err;
    logic         e_init;
    logic         e_next;
    logic [511:0] e_block;

    logic         resp_rdy;
    logic         resp_vld;
    logic [255:0] resp_dig;
    logic [255:0] resp_base;
    int           busy;

    int           checks = 0;
    int           errors = 0;
    logic [31:0]  mblk [16];
    int           pend = 0;
    logic [255:0] exp_dig;

    localparam logic [255:0] IV = 256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0;

    always #5 clk = ~clk;

    hash_bus_regs uut (
        .clk              (clk),
        .rst              (rst),
        .bus_stb          (stb),
        .bus_we           (bwe),
        .bus_addr         (addr),
        .bus_wdata        (wdata),
        .bus_rdata        (rdata),
        .bus_ack          (ack),
        .bus_err          (err),
        .eng_init         (e_init),
        .eng_next         (e_next),
        .eng_block        (e_block),
        .eng_ready        (resp_rdy),
        .eng_digest       (resp_dig),
        .eng_digest_valid (resp_vld)
    );

    function automatic logic [255:0] mix(input logic [255:0] base, input logic [511:0] blk);
        logic [255:0] o;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] b1;
            logic [31:0] b2;
            b1 = blk[511-32*k -: 32];
            b2 = blk[255-32*k -: 32];
            o[255-32*k -: 32] = base[255-32*k -: 32] + (b1 ^ {b2[30:0], b2[31]}) + 32'(k);
        end
        return o;
    endfunction

    function automatic logic [511:0] model_block();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[511-32*i -: 32] = mblk[i];
        return v;
    endfunction

    // Behavioural engine: answers a command after four cycles.
    always @(posedge clk) begin
        if (rst) begin
            resp_rdy  <= 1'b1;
            resp_vld  <= 1'b0;
            resp_dig  <= '0;
            resp_base <= '0;
            busy      <= 0;
        end else if (e_init || e_next) begin
            resp_rdy  <= 1'b0;
            resp_vld  <= 1'b0;
            resp_base <= e_init ? IV : resp_dig;
            busy      <= 4;
        end else if (busy != 0) begin
            busy <= busy - 1;
            if (busy == 1) begin
                resp_dig <= mix(resp_base, e_block);
                resp_rdy <= 1'b1;
                resp_vld <= 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the reference model.
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check("R4 block bus", e_block, model_block());
            check("R3 init pulse", 512'(e_init), 512'(pend == 1));
            check("R3 next pulse", 512'(e_next), 512'(pend == 2));
            if (!stb) check("R7 idle response", 512'({ack, err}), 512'(0));
        end
        pend = 0;
    end

    // One strobe cycle; called at a falling edge, returns at a falling edge.
    task automatic bus(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] exp_rd, input bit exp_ack, input string req);
        stb = 1'b1; bwe = we; addr = a; wdata = d;
        #2;
        check({req, " ack"}, 512'(ack), 512'(exp_ack));
        check({req, " err"}, 512'(err), 512'(!exp_ack));
        if (!we) check({req, " data"}, 512'(rdata), 512'(exp_rd));
        @(posedge clk);
        if (we && exp_ack) begin
            if (a >= 8'h10 && a <= 8'h1f) mblk[a - 8'h10] = d;
            if (a == 8'h08) pend = d[0] ? 1 : (d[1] ? 2 : 0);
        end
        @(negedge clk);
        stb = 1'b0; bwe = 1'b0;
    endtask

    task automatic poll_done(input string req);
        logic [31:0] st = '0;
        int tries = 0;
        while (st == 0 && tries < 40) begin
            stb = 1'b1; bwe = 1'b0; addr = 8'h09;
            #2;
            st = rdata;
            check({req, " status"}, 512'(st), 512'({30'd0, resp_vld, resp_rdy}));
            @(negedge clk);
            stb = 1'b0;
            tries++;
        end
        check({req, " completes"}, 512'(st), 512'(3));
    endtask

    task automatic read_digest(input logic [255:0] expd, input string req);
        for (int i = 0; i < 8; i++)
            bus(1'b0, 8'h20 + 8'(i), '0, expd[255-32*i -: 32], 1'b1, req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mblk[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R9 reset state
        bus(1'b0, 8'h08, '0, 32'd0, 1'b1, "R9 ctrl after reset");
        bus(1'b0, 8'h1f, '0, 32'd0, 1'b1, "R9 block after reset");

        // R1 identity
        bus(1'b0, 8'h00, '0, 32'h68617368, 1'b1, "R1 name hi");
        bus(1'b0, 8'h01, '0, 32'h62616e6b, 1'b1, "R1 name lo");
        bus(1'b0, 8'h02, '0, 32'h302e3930, 1'b1, "R1 version");

        // R4 block load and readback
        for (int i = 0; i < 16; i++)
            bus(1'b1, 8'h10 + 8'(i), 32'ha0000000 + 32'h01010101 * 32'(i) + 32'(i * 7), '0, 1'b1, "R4 write");
        bus(1'b0, 8'h10, '0, mblk[0], 1'b1, "R4 read first");
        bus(1'b0, 8'h17, '0, mblk[7], 1'b1, "R4 read mid");
        bus(1'b0, 8'h1f, '0, mblk[15], 1'b1, "R4 read last");
        check("R4 top word order", e_block[511:480], 512'(mblk[0]));

        // R3 init then immediate clear, R5 polling, R6 digest
        bus(1'b1, 8'h08, 32'd1, '0, 1'b1, "R3 init write");
        bus(1'b1, 8'h08, 32'd0, '0, 1'b1, "R3 clear write");
        poll_done("R5 init");
        exp_dig = mix(IV, model_block());
        read_digest(exp_dig, "R6 init digest");

        // R3 next chains from previous digest
        for (int i = 0; i < 16; i += 3)
            bus(1'b1, 8'h10 + 8'(i), 32'h5a5a0000 ^ 32'(i * 977), '0, 1'b1, "R4 rewrite");
        bus(1'b1, 8'h08, 32'd2, '0, 1'b1, "R3 next write");
        bus(1'b0, 8'h08, '0, 32'd2, 1'b1, "R2 ctrl readback next");
        bus(1'b1, 8'h08, 32'd0, '0, 1'b1, "R3 clear write");
        poll_done("R5 next");
        exp_dig = mix(exp_dig, model_block());
        read_digest(exp_dig, "R6 chained digest");

        // R3 both bits: init only; bits held set give no further pulse
        bus(1'b1, 8'h08, 32'hffff_fff3, '0, 1'b1, "R3 both bits");
        bus(1'b0, 8'h08, '0, 32'd3, 1'b1, "R2 ctrl readback both");
        idle(6);
        bus(1'b1, 8'h08, 32'd0, '0, 1'b1, "R3 clear write");
        poll_done("R5 both");
        exp_dig = mix(IV, model_block());
        read_digest(exp_dig, "R6 both-bit digest");

        // R3 back-to-back commands: init then next in consecutive cycles
        bus(1'b1, 8'h08, 32'd1, '0, 1'b1, "R3 b2b init");
        bus(1'b1, 8'h08, 32'd2, '0, 1'b1, "R3 b2b next");
        bus(1'b1, 8'h08, 32'd0, '0, 1'b1, "R3 b2b clear");
        poll_done("R5 b2b");

        // R7 and R8: unmapped and read-only accesses
        bus(1'b0, 8'h03, '0, 32'd0, 1'b0, "R8 read gap");
        bus(1'b0, 8'h0f, '0, 32'd0, 1'b0, "R8 read below block");
        bus(1'b0, 8'h28, '0, 32'd0, 1'b0, "R8 read past digest");
        bus(1'b0, 8'hff, '0, 32'd0, 1'b0, "R8 read top");
        bus(1'b1, 8'h09, 32'd1, '0, 1'b0, "R7 write status");
        bus(1'b1, 8'h20, 32'd1, '0, 1'b0, "R7 write digest");
        bus(1'b1, 8'h00, 32'd1, '0, 1'b0, "R7 write name");
        bus(1'b1, 8'h40, 32'd1, '0, 1'b0, "R7 write unmapped");
        bus(1'b0, 8'h00, '0, 32'h68617368, 1'b1, "R8 name unchanged");
        bus(1'b0, 8'h08, '0, 32'd0, 1'b1, "R8 ctrl unchanged");
        bus(1'b0, 8'h10, '0, mblk[0], 1'b1, "R8 block unchanged");

        // R9 reset in the middle of operation
        bus(1'b1, 8'h08, 32'd2, '0, 1'b1, "R9 ctrl set");
        rst = 1'b1;
        idle(2);
        for (int i = 0; i < 16; i++) mblk[i] = '0;
        pend = 0;
        rst = 1'b0;
        idle(1);
        bus(1'b0, 8'h08, '0, 32'd0, 1'b1, "R9 ctrl cleared");
        bus(1'b0, 8'h15, '0, 32'd0, 1'b1, "R9 block cleared");
        check("R9 block bus cleared", e_block, 512'd0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule